// File: doc/BRIEF.md
# Peer-Voted Controller Restart Resolver

This block is the hard-core recovery unit for a group of three loosely synchronized controllers that run the same program. Each controller drives a two-bit action code and a two-bit target code into the resolver. From these the resolver decides, every clock, whether any controller must be held in reset or have its supply switched off and then back on. It drives one reset line and one power-enable line per controller.

Two kinds of request act on the requester's word alone: a request aimed at the requester itself, and a request aimed at all three controllers. A request against a peer only acts when both of that peer's neighbours ask for the same action in the same cycle, so a single faulty controller cannot take down a healthy one. Once a reset is asserted it is held for a minimum number of clocks. Once power is removed it stays off until an external sensor confirms that the supply current has fallen and no power-cycle request remains. An overcurrent flag removes power at once, without waiting for a clock edge or for any vote.

Top module: `peer_restart_arbiter`

## Requirements
- R1: `online[i]` is 1 exactly when controller i's action code `req_code[2i+1:2i]` differs from 00 (00 = idle offline). The flag is combinational, with no register delay.
- R2: Action codes: 01 is a reset vote, 10 is a power-cycle vote, 11 (idle online) and 00 request nothing. Target codes in `dev_sel[2i+1:2i]`: 00 = self/all, 01 = right peer (controller (i+1) mod 3), 10 = left peer (controller (i+2) mod 3), 11 = both peers.
- R3: A power-cycle vote with target 00 clears that requester's `pwr_en` at the next clock edge, with no second vote.
- R4: Action 01 with target 00 means power-cycle all. It clears every `pwr_en` at the next clock edge, with no second vote.
- R5: A reset or power-cycle vote against a peer from only one controller has no effect on that peer's outputs.
- R6: When both other controllers vote to reset controller t in the same cycle, `ctl_reset[t]` rises at the next edge. It then stays high for at least RST_HOLD clocks, and for as long as both votes remain.
- R7: When a power-cycle action and a two-vote reset are both satisfied for the same target in the same cycle, the power-cycle wins: power is removed and `ctl_reset` stays low.
- R8: After power has been removed, `pwr_en[t]` returns to 1 only at the edge after a cycle in which `off_ok[t]` is 1, `overcurrent[t]` is 0 and no power-cycle action targets t.
- R9: `overcurrent[t]` clears `pwr_en[t]` in the same cycle, with no clock edge needed. Power then stays off after the flag drops, under the R8 rule.
- R10: During and right after an asynchronous reset (`rst_n` low), all `pwr_en` bits are 1 and all `ctl_reset` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_code | input | 6 | Action code of controller i in bits [2i+1:2i] |
| dev_sel | input | 6 | Target code of controller i in bits [2i+1:2i] |
| overcurrent | input | 3 | Per-controller supply overcurrent flag |
| off_ok | input | 3 | Per-controller flag: supply current below the off threshold |
| ctl_reset | output | 3 | Per-controller reset, active high |
| pwr_en | output | 3 | Per-controller power switch enable |
| online | output | 3 | Per-controller participation flag |

## Verification
The bench builds the block with RST_HOLD = 3. This setting keeps the minimum reset hold clearly apart from request tracking: a reset whose votes drop after one cycle must still stay high for two more clocks. Directed phases cover each target code, the power-cycle-all code, single versus double peer votes, and priority between the two actions. They also cover the off-confirmation gate and the combinational overcurrent path. A long randomized phase then mixes all codes with random confirmation and rare overcurrent flags, and compares every output each clock against a behavioural vote-tally model.

// File: rtl/peer_restart_arbiter.sv
module peer_restart_arbiter #(
  parameter int RST_HOLD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] req_code,
  input  logic [5:0] dev_sel,
  input  logic [2:0] overcurrent,
  input  logic [2:0] off_ok,
  output logic [2:0] ctl_reset,
  output logic [2:0] pwr_en,
  output logic [2:0] online
);
  localparam int NC = 3;
  localparam int CW = (RST_HOLD < 2) ? 1 : $clog2(RST_HOLD + 1);
  localparam logic [1:0] A_RST = 2'b01;
  localparam logic [1:0] A_CYC = 2'b10;
  localparam logic [1:0] S_SELF = 2'b00;

  logic [1:0] rq [NC];
  logic [1:0] sl [NC];
  logic [NC-1:0] rst_act, cyc_act;
  logic [NC-1:0] pwr_q, rs_q;
  logic [CW-1:0] cnt_q [NC];

  for (genvar i = 0; i < NC; i++) begin : g_split
    assign rq[i] = req_code[2*i +: 2];
    assign sl[i] = dev_sel[2*i +: 2];
    assign online[i] = (rq[i] != 2'b00);
  end

  always_comb begin
    logic all_c;
    logic [1:0] rv, cv;
    logic hit;
    int j;
    all_c = 1'b0;
    for (int k = 0; k < NC; k++)
      if (rq[k] == A_RST && sl[k] == S_SELF) all_c = 1'b1;
    for (int t = 0; t < NC; t++) begin
      rv = 2'd0;
      cv = 2'd0;
      for (int k = 1; k < NC; k++) begin
        j = (t + k) % NC;
        hit = (k == 2) ? sl[j][0] : sl[j][1];
        if (hit && rq[j] == A_RST) rv = rv + 2'd1;
        if (hit && rq[j] == A_CYC) cv = cv + 2'd1;
      end
      cyc_act[t] = all_c || (rq[t] == A_CYC && sl[t] == S_SELF) || (cv == 2'd2);
      rst_act[t] = (rv == 2'd2) && !cyc_act[t];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= '1;
      rs_q  <= '0;
      for (int t = 0; t < NC; t++) cnt_q[t] <= '0;
    end else begin
      for (int t = 0; t < NC; t++) begin
        if (overcurrent[t] || cyc_act[t]) pwr_q[t] <= 1'b0;
        else if (!pwr_q[t] && off_ok[t]) pwr_q[t] <= 1'b1;

        if (!rs_q[t]) begin
          if (rst_act[t]) begin
            rs_q[t]  <= 1'b1;
            cnt_q[t] <= CW'(RST_HOLD - 1);
          end
        end else if (cnt_q[t] != '0) begin
          cnt_q[t] <= cnt_q[t] - 1'b1;
        end else if (!rst_act[t]) begin
          rs_q[t] <= 1'b0;
        end
      end
    end
  end

  assign ctl_reset = rs_q;
  assign pwr_en    = pwr_q & ~overcurrent;

  for (genvar t = 0; t < NC; t++) begin : g_chk
    logic [CW-1:0] hcnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hcnt <= '0;
      else if (!rs_q[t]) hcnt <= '0;
      else if (hcnt != CW'(RST_HOLD)) hcnt <= hcnt + 1'b1;
    end

    p_self_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rq[t] == A_CYC && sl[t] == S_SELF) |=> !pwr_q[t]);

    p_cycle_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rq[t] == A_RST && sl[t] == S_SELF) |=> (pwr_q == '0));

    p_reset_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rs_q[t]) |-> (hcnt >= CW'(RST_HOLD)));

    p_power_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_q[t]) |-> ($past(off_ok[t]) && !$past(overcurrent[t])));

    p_overcurrent_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      overcurrent[t] |=> !pwr_q[t]);
  end
endmodule

// File: tb/peer_restart_arbiter_tb.sv
module peer_restart_arbiter_tb;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] req_code = 6'b111111;
  logic [5:0] dev_sel = 6'b000000;
  logic [2:0] overcurrent = 3'b000;
  logic [2:0] off_ok = 3'b111;
  logic [2:0] ctl_reset, pwr_en, online;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit m_pwr [3];
  bit m_rs  [3];
  int m_age [3];

  always #2 clk = ~clk;

  peer_restart_arbiter #(.RST_HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_code(req_code), .dev_sel(dev_sel),
    .overcurrent(overcurrent), .off_ok(off_ok),
    .ctl_reset(ctl_reset), .pwr_en(pwr_en), .online(online));

  // behavioural reference: tally votes per target, then step each machine
  always @(posedge clk or negedge rst_n) begin : model
    int rv [3];
    int cv [3];
    bit sc [3];
    bit all_c;
    bit cyc, rst;
    int r, s;
    if (!rst_n) begin
      for (int t = 0; t < 3; t++) begin m_pwr[t] = 1; m_rs[t] = 0; m_age[t] = 0; end
    end else begin
      all_c = 0;
      for (int t = 0; t < 3; t++) begin rv[t] = 0; cv[t] = 0; sc[t] = 0; end
      for (int j = 0; j < 3; j++) begin
        r = int'(req_code[2*j +: 2]);
        s = int'(dev_sel[2*j +: 2]);
        if (s == 0) begin
          if (r == 1) all_c = 1;
          if (r == 2) sc[j] = 1;
        end else begin
          if (s == 1 || s == 3) begin
            if (r == 1) rv[(j+1)%3]++;
            if (r == 2) cv[(j+1)%3]++;
          end
          if (s == 2 || s == 3) begin
            if (r == 1) rv[(j+2)%3]++;
            if (r == 2) cv[(j+2)%3]++;
          end
        end
      end
      for (int t = 0; t < 3; t++) begin
        cyc = sc[t] || all_c || cv[t] >= 2;
        rst = rv[t] >= 2 && !cyc;
        if (overcurrent[t] || cyc) m_pwr[t] = 0;
        else if (!m_pwr[t] && off_ok[t]) m_pwr[t] = 1;
        if (!m_rs[t]) begin
          if (rst) begin m_rs[t] = 1; m_age[t] = 1; end
        end else if (m_age[t] >= HOLD && !rst) m_rs[t] = 0;
        else m_age[t]++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    logic [2:0] e_rst, e_pwr, e_on;
    for (int t = 0; t < 3; t++) begin
      e_rst[t] = m_rs[t];
      e_pwr[t] = m_pwr[t] && !overcurrent[t];
      e_on[t]  = (req_code[2*t +: 2] != 2'b00);
    end
    check(ctl_reset === e_rst, "R6 model ctl_reset", int'(ctl_reset), int'(e_rst));
    check(pwr_en === e_pwr, "R8 model pwr_en", int'(pwr_en), int'(e_pwr));
    check(online === e_on, "R1 model online", int'(online), int'(e_on));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_model();
  endtask

  task automatic set_ctl(input int i, input logic [1:0] r, input logic [1:0] s);
    req_code[2*i +: 2] = r;
    dev_sel[2*i +: 2]  = s;
  endtask

  task automatic idle_all();
    req_code = 6'b111111;
    dev_sel  = 6'b000000;
  endtask

  initial begin
    repeat (3) tick();
    check(pwr_en == 3'b111, "R10 pwr_en after reset", int'(pwr_en), 7);
    check(ctl_reset == 3'b000, "R10 ctl_reset after reset", int'(ctl_reset), 0);
    rst_n = 1'b1;
    tick();
    check(pwr_en == 3'b111 && ctl_reset == 3'b000, "R10 first cycle out of reset",
          int'({ctl_reset, pwr_en}), 7);

    // R1: controller 1 idle offline
    set_ctl(1, 2'b00, 2'b00);
    #1 check(online == 3'b101, "R1 online flags", int'(online), 5);
    tick();
    idle_all();

    // R5: one peer reset vote only (ctl 1 -> left = ctl 0)
    set_ctl(1, 2'b01, 2'b10);
    tick(); tick();
    check(ctl_reset == 3'b000, "R5 single reset vote ignored", int'(ctl_reset), 0);
    check(pwr_en == 3'b111, "R5 power untouched", int'(pwr_en), 7);

    // R6: second vote (ctl 2 -> right = ctl 0)
    set_ctl(2, 2'b01, 2'b01);
    tick();
    check(ctl_reset == 3'b001, "R6 two reset votes", int'(ctl_reset), 1);
    idle_all();
    tick(); tick();
    check(ctl_reset == 3'b001, "R6 reset held to minimum", int'(ctl_reset), 1);
    tick();
    check(ctl_reset == 3'b000, "R6 reset released after hold", int'(ctl_reset), 0);

    // R7: reset pair plus self power-cycle on ctl 0, off_ok low
    off_ok = 3'b000;
    set_ctl(1, 2'b01, 2'b10);
    set_ctl(2, 2'b01, 2'b01);
    set_ctl(0, 2'b10, 2'b00);
    tick();
    check(pwr_en[0] == 1'b0, "R7 cycle wins: power off", int'(pwr_en), 6);
    check(ctl_reset == 3'b000, "R7 cycle wins: no reset", int'(ctl_reset), 0);
    idle_all();
    tick(); tick();
    check(pwr_en == 3'b110, "R8 stays off without off_ok", int'(pwr_en), 6);
    off_ok = 3'b111;
    tick();
    check(pwr_en == 3'b111, "R8 returns after off_ok", int'(pwr_en), 7);

    // R3: self power-cycle on ctl 2
    set_ctl(2, 2'b10, 2'b00);
    tick();
    check(pwr_en == 3'b011, "R3 self cycle", int'(pwr_en), 3);
    idle_all();
    tick();
    check(pwr_en == 3'b111, "R8 self cycle recovery", int'(pwr_en), 7);

    // R4: reset-self code means power-cycle all
    set_ctl(1, 2'b01, 2'b00);
    tick();
    check(pwr_en == 3'b000, "R4 cycle all", int'(pwr_en), 0);
    check(ctl_reset == 3'b000, "R4 no reset from cycle all", int'(ctl_reset), 0);
    idle_all();
    tick();
    check(pwr_en == 3'b111, "R4 recovery", int'(pwr_en), 7);

    // R2: both-peers target from ctl 0 and ctl 1 hits only ctl 2 twice
    set_ctl(0, 2'b10, 2'b11);
    set_ctl(1, 2'b10, 2'b11);
    tick();
    check(pwr_en == 3'b011, "R2 both-peers select", int'(pwr_en), 3);
    idle_all();
    tick();
    // R2: idle online code requests nothing whatever the target
    set_ctl(0, 2'b11, 2'b11);
    set_ctl(1, 2'b11, 2'b10);
    set_ctl(2, 2'b11, 2'b01);
    tick(); tick();
    check(pwr_en == 3'b111 && ctl_reset == 3'b000, "R2 idle online no action",
          int'({ctl_reset, pwr_en}), 7);
    idle_all();

    // R9: overcurrent acts without a clock edge
    tick();
    overcurrent = 3'b010;
    #1 check(pwr_en == 3'b101, "R9 immediate power off", int'(pwr_en), 5);
    tick();
    check(pwr_en == 3'b101, "R9 held while flagged", int'(pwr_en), 5);
    off_ok = 3'b101;
    overcurrent = 3'b000;
    tick();
    check(pwr_en == 3'b101, "R9 stays off after flag drops", int'(pwr_en), 5);
    off_ok = 3'b111;
    tick();
    check(pwr_en == 3'b111, "R8 recovery after overcurrent", int'(pwr_en), 7);

    // randomized phase against the model
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < 3; i++) begin
        if ($urandom_range(3, 0) == 0) set_ctl(i, 2'($urandom), 2'($urandom));
        else set_ctl(i, 2'b11, 2'($urandom));
      end
      off_ok = 3'($urandom);
      overcurrent = ($urandom_range(15, 0) == 0) ? 3'($urandom) : 3'b000;
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule